// File: doc/BRIEF.md
# Fan Tachometer with Programmable Prescaler

This block measures how fast a fan turns by timing the interval between successive rising edges of its tachometer signal. A slow reference enable (nominally a 480 kHz tick) is divided by 1, 2, 4 or 8 to form a count tick. A saturating period counter advances on each count tick and is captured into a readback register on every qualified tachometer edge. A long period means a slow fan. The slowest measurable speed is therefore reference / (255 × divider). Software turns counts into speed and picks the divider itself.

Two sticky alarms report trouble. A "slow" alarm is set when a captured period exceeds a programmable limit count. A "stalled" alarm is set when the counter saturates before the next edge arrives. Both stay set until software reads the status register. A trigger that lands in the same cycle as that read wins over the clear.

The register port is plain control: one address, a write strobe and a read strobe. Read data returns exactly one cycle after the read strobe, marked by a one-cycle valid. The port has no ready signal and applies no back-pressure: every read strobe is answered, and the requester must take the data in the cycle it is valid.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset the divider select reads 0, the limit reads 0xFF, the captured count reads 0 and the status reads 0.
- R2: The period counter advances once per 2^sel reference ticks, where sel is the divider select value (0..3). Reference ticks are counted from the most recent restart.
- R3: On a qualified rising tachometer edge, the running count is copied to the count register and the counter and prescaler restart from zero.
- R4: The running count saturates at 255 and holds there until the next edge. A capture made while saturated reads 255.
- R5: The slow alarm (status bit 0) is set when a captured count is strictly greater than the limit, or when the counter saturates while the limit is below 255.
- R6: The stalled alarm (status bit 1) is set when the counter reaches 255, or when a count of 255 is captured.
- R7: Alarms stay set until a read of the status register. That read returns the value held before the clear, and the alarms are clear afterwards.
- R8: An alarm trigger in the same cycle as a status read leaves that alarm set.
- R9: The first rising edge after reset, or after any write of the divider select, only arms the measurement. It changes neither the count register nor the alarms.
- R10: Address map: 0 holds the divider select in bits 1:0, 1 holds the limit, 2 holds the count (read only), and 3 holds the status (read only). Writes to 2 and 3 are ignored. reg_rvalid pulses exactly one cycle after reg_rd.
- R11: The tachometer input is synchronized through two flops. Falling edges have no effect on the count. Pulses must last at least two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference time-base enable |
| tach_in | input | 1 | Raw tachometer signal, asynchronous |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 2-bit divider select and two synchronizer stages. It drives the reference enable itself, at one pulse every two clocks, rather than waiting for a real 480 kHz rate. This puts saturation at the largest divider (2040 ticks) within a few thousand cycles, so the 254-versus-255 boundary and the stall-only and stall-plus-slow cases can be exercised directly. A scoreboard queues expected read data and checks each returned value, including a status read placed in the exact cycle of an alarm trigger.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIV    = 2'd0,
    REG_LIMIT  = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } tach_reg_e;

  localparam int ST_SLOW_BIT  = 0;
  localparam int ST_STALL_BIT = 1;
endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic rise_pulse
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= raw_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= 1'b0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign rise_pulse = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             restart,
  input  logic [SEL_W-1:0] div_sel,
  output logic             cnt_tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam logic [PRE_W:0]   ONE_W  = 1;
  localparam logic [PRE_W-1:0] ONE_P  = 1;

  logic [PRE_W:0]   div_hot;
  logic [PRE_W-1:0] last_val;
  logic [PRE_W-1:0] pre_cnt;
  logic             at_last;

  assign div_hot  = ONE_W << div_sel;
  assign last_val = div_hot[PRE_W-1:0] - ONE_P;
  assign at_last  = (pre_cnt == last_val);
  assign cnt_tick = ref_tick & at_last & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (restart)  pre_cnt <= '0;
    else if (ref_tick) pre_cnt <= at_last ? '0 : pre_cnt + ONE_P;
  end
endmodule

// File: rtl/tach_period_ctr.sv
module tach_period_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_pulse,
  input  logic             disarm,
  input  logic             cnt_tick,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] cap_cnt,
  output logic             cap_evt,
  output logic             sat_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_PEN = CNT_MAX - CNT_ONE;

  logic armed;

  assign cap_evt = edge_pulse & armed & ~disarm;
  assign sat_evt = cnt_tick & (run_cnt == CNT_PEN) & ~edge_pulse & ~disarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (disarm)     armed <= 1'b0;
    else if (edge_pulse) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_cnt <= '0;
    else if (edge_pulse || disarm)       run_cnt <= '0;
    else if (cnt_tick && run_cnt != CNT_MAX) run_cnt <= run_cnt + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_cnt <= '0;
    else if (cap_evt) cap_cnt <= run_cnt;
  end
endmodule

// File: rtl/tach_csr.sv
module tach_csr
  import tach_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic              cap_evt,
  input  logic              sat_evt,
  input  logic [CNT_W-1:0]  run_cnt,
  input  logic [CNT_W-1:0]  cap_cnt,
  output logic [SEL_W-1:0]  div_sel,
  output logic              div_wr,
  output logic              alarm_slow,
  output logic              alarm_stall,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              reg_rvalid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] limit;
  logic             stat_rd;
  logic             slow_set;
  logic             stall_set;
  logic [CNT_W-1:0] rd_mux;

  assign div_wr    = reg_wr & (reg_addr == REG_DIV);
  assign stat_rd   = reg_rd & (reg_addr == REG_STATUS);
  assign slow_set  = (cap_evt & (run_cnt > limit)) | (sat_evt & (CNT_MAX > limit));
  assign stall_set = (cap_evt & (run_cnt == CNT_MAX)) | sat_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= '0;
      limit   <= CNT_MAX;
    end else if (reg_wr) begin
      if (reg_addr == REG_DIV)   div_sel <= reg_wdata[SEL_W-1:0];
      if (reg_addr == REG_LIMIT) limit   <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alarm_slow <= 1'b0;
    else if (slow_set)  alarm_slow <= 1'b1;
    else if (stat_rd)   alarm_slow <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alarm_stall <= 1'b0;
    else if (stall_set) alarm_stall <= 1'b1;
    else if (stat_rd)   alarm_stall <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      REG_DIV:    rd_mux = CNT_W'(div_sel);
      REG_LIMIT:  rd_mux = limit;
      REG_COUNT:  rd_mux = cap_cnt;
      default: begin
        rd_mux[ST_SLOW_BIT]  = alarm_slow;
        rd_mux[ST_STALL_BIT] = alarm_stall;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import tach_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              tach_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              reg_rvalid
);
  logic             edge_pulse;
  logic             cnt_tick;
  logic             div_wr;
  logic [SEL_W-1:0] div_sel;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] cap_cnt;
  logic             cap_evt;
  logic             sat_evt;
  logic             alarm_slow;
  logic             alarm_stall;

  tach_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_in     (tach_in),
    .rise_pulse (edge_pulse)
  );

  tach_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .restart  (edge_pulse | div_wr),
    .div_sel  (div_sel),
    .cnt_tick (cnt_tick)
  );

  tach_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_pulse (edge_pulse),
    .disarm     (div_wr),
    .cnt_tick   (cnt_tick),
    .run_cnt    (run_cnt),
    .cap_cnt    (cap_cnt),
    .cap_evt    (cap_evt),
    .sat_evt    (sat_evt)
  );

  tach_csr #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .cap_evt     (cap_evt),
    .sat_evt     (sat_evt),
    .run_cnt     (run_cnt),
    .cap_cnt     (cap_cnt),
    .div_sel     (div_sel),
    .div_wr      (div_wr),
    .alarm_slow  (alarm_slow),
    .alarm_stall (alarm_stall),
    .reg_rdata   (reg_rdata),
    .reg_rvalid  (reg_rvalid)
  );
endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             reg_rvalid,
  input logic             edge_pulse,
  input logic             cnt_tick,
  input logic             cap_evt,
  input logic             sat_evt,
  input logic [CNT_W-1:0] run_cnt,
  input logic [CNT_W-1:0] cap_cnt,
  input logic             alarm_slow,
  input logic             alarm_stall
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic restart_c;
  logic stat_rd_c;
  assign restart_c = edge_pulse | (reg_wr & (reg_addr == 2'd0));
  assign stat_rd_c = reg_rd & (reg_addr == 2'd3);

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R10
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid); // R10
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_c |=> (run_cnt == '0)); // R3
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_cnt == $past(run_cnt))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_c && run_cnt != CNT_MAX) |=>
      (run_cnt == $past(run_cnt) + CNT_W'($past(cnt_tick)))); // R2
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_c && run_cnt == CNT_MAX) |=> (run_cnt == CNT_MAX)); // R4
  AST_SAT_RAISES_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> alarm_stall); // R6
  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_c && sat_evt) |=> alarm_stall); // R8
  AST_STICKY_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_slow && !stat_rd_c) |=> alarm_slow); // R7
  AST_STICKY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_stall && !stat_rd_c) |=> alarm_stall); // R7
  AST_CLEAR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_c && !sat_evt && !cap_evt) |=> !alarm_stall); // R7
endmodule

bind fan_tach_meter fan_tach_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_rvalid  (reg_rvalid),
  .edge_pulse  (edge_pulse),
  .cnt_tick    (cnt_tick),
  .cap_evt     (cap_evt),
  .sat_evt     (sat_evt),
  .run_cnt     (run_cnt),
  .cap_cnt     (cap_cnt),
  .alarm_slow  (alarm_slow),
  .alarm_stall (alarm_stall)
);

// File: tb/test_fan_tach_meter.sv
module test_fan_tach_meter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       tach_in = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       reg_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  fan_tach_meter i_fan_tach_meter (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tach_in(tach_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected read data actual %h expected none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    clk_n(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1; @(negedge clk);
      ref_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic tach_pulse();
    tach_in = 1'b1; clk_n(4);
    tach_in = 1'b0; clk_n(3);
  endtask

  task automatic measure(input int n);
    ticks(n);
    tach_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clk_n(3);
    rst_n = 1'b1;
    clk_n(2);
    // R1 reset state
    rd_expect(2'd0, 8'h00, "R1 divider");
    rd_expect(2'd1, 8'hFF, "R1 limit");
    rd_expect(2'd2, 8'h00, "R1 count");
    rd_expect(2'd3, 8'h00, "R1 status");

    tach_pulse();                               // R9 arming edge
    rd_expect(2'd2, 8'h00, "R9 arm edge count");
    measure(100);
    rd_expect(2'd2, 8'd100, "R3 count div1");
    rd_expect(2'd3, 8'h00, "R5 no alarm at limit FF");

    wr(2'd1, 8'd50);
    rd_expect(2'd1, 8'd50, "R10 limit readback");
    measure(50);
    rd_expect(2'd2, 8'd50, "R3 count 50");
    rd_expect(2'd3, 8'h00, "R5 equal to limit");
    measure(51);
    rd_expect(2'd2, 8'd51, "R3 count 51");
    rd_expect(2'd3, 8'h01, "R5 above limit");
    rd_expect(2'd3, 8'h00, "R7 cleared by read");

    wr(2'd2, 8'h77);
    wr(2'd3, 8'h03);
    rd_expect(2'd2, 8'd51, "R10 count write ignored");
    rd_expect(2'd3, 8'h00, "R10 status write ignored");

    wr(2'd0, 8'd2);
    rd_expect(2'd0, 8'd2, "R10 divider readback");
    measure(40);
    rd_expect(2'd2, 8'd51, "R9 edge after divider write");
    rd_expect(2'd3, 8'h00, "R9 no alarm on arm edge");
    measure(203);
    rd_expect(2'd2, 8'd50, "R2 div4 count");
    rd_expect(2'd3, 8'h00, "R2 div4 no alarm");
    measure(207);
    rd_expect(2'd2, 8'd51, "R2 div4 count 51");
    rd_expect(2'd3, 8'h01, "R5 div4 alarm");
    rd_expect(2'd3, 8'h00, "R7 clear");

    measure(404);
    measure(40);
    rd_expect(2'd2, 8'd10, "R2 fast count");
    rd_expect(2'd3, 8'h01, "R7 sticky after recovery");
    rd_expect(2'd3, 8'h00, "R7 clear after sticky");

    wr(2'd1, 8'hFF);
    wr(2'd0, 8'd3);
    tach_pulse();
    measure(2039);
    rd_expect(2'd2, 8'd254, "R4 just below saturation");
    rd_expect(2'd3, 8'h00, "R6 no stall at 254");
    ticks(2040);
    rd_expect(2'd2, 8'd254, "R4 saturation without edge keeps count");
    rd_expect(2'd3, 8'h02, "R6 stall only with limit FF");
    rd_expect(2'd3, 8'h00, "R7 stall cleared");
    wr(2'd1, 8'd50);
    ticks(100);
    rd_expect(2'd3, 8'h00, "R4 held saturation raises once");
    tach_pulse();
    rd_expect(2'd2, 8'd255, "R4 capture of saturated count");
    rd_expect(2'd3, 8'h03, "R6 stall and slow on capture");
    rd_expect(2'd3, 8'h00, "R7 both cleared");

    wr(2'd0, 8'd0);
    tach_pulse();
    rd_expect(2'd3, 8'h00, "R8 precondition");
    ticks(60);
    tach_in = 1'b1;
    clk_n(2);
    exp_q.push_back(8'h00);
    tag_q.push_back("R8 read in trigger cycle");
    reg_rd = 1'b1; reg_addr = 2'd3;
    @(negedge clk);
    reg_rd = 1'b0;
    clk_n(2);
    tach_in = 1'b0;
    clk_n(3);
    rd_expect(2'd2, 8'd60, "R8 capture");
    rd_expect(2'd3, 8'h01, "R8 set wins over clear");
    rd_expect(2'd3, 8'h00, "R7 clear after R8");

    wr(2'd1, 8'hFF);
    measure(30);
    rd_expect(2'd2, 8'd30, "R11 base count");
    ticks(12);
    tach_in = 1'b1; clk_n(4);
    rd_expect(2'd2, 8'd12, "R11 rising edge capture");
    ticks(20);
    tach_in = 1'b0; clk_n(4);
    ticks(5);
    rd_expect(2'd2, 8'd12, "R11 falling edge ignored");
    tach_in = 1'b1; clk_n(4);
    tach_in = 1'b0; clk_n(3);
    rd_expect(2'd2, 8'd25, "R11 period spans falling edge");

    clk_n(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing read data actual %0d pending expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule